// File: doc/BRIEF.md
# DRAM Refresh Scheduler

The scheduler keeps an eight-bank DRAM within its retention window by counting controller clock cycles and turning each elapsed refresh interval into one unit of refresh debt. While debt is owed and the target banks are idle it raises a request toward the command arbiter. A grant in the same cycle as the request retires one unit of debt and marks the refreshed banks busy for the refresh cycle time. The arbiter may postpone refreshes. Debt saturates at eight postponed refreshes, and at that point an urgent flag tells the arbiter to serve refresh ahead of all other traffic.

Two modes are supported. All-bank refresh uses an interval of 3.9 µs and occupies every bank. Per-bank refresh uses one eighth of that interval and visits the banks in rotation. A 2-bit rate input shortens the interval by 2x or 4x when the die runs hot. The mode and rate inputs are sampled only at an interval boundary. Every time limit is given in picoseconds and converted to whole clock cycles by parameter.

Top module: `ref_sched`

## Requirements
- R1: After reset the block shows no request, zero debt, no busy bank and no urgent flag. All-bank mode at 1x rate is in force.
- R2: In all-bank mode the interval is ceil(REFI_PS / CLK_PS) cycles, 488 at defaults. The rate code selects that value (0), half of it (1) or a quarter of it (2 or 3), with each fraction rounded down.
- R3: In per-bank mode the interval is ceil(REFI_PS / 8 / CLK_PS) cycles, 61 at defaults. It is scaled by the same rate codes.
- R4: A change on mode_i or rate_i does not alter the interval that is running. It takes effect from the next interval boundary.
- R5: req_o is high exactly when debt is nonzero and the target is idle. In all-bank mode (req_all_o = 1) the target is every bank. In per-bank mode (req_all_o = 0) it is the bank on req_bank_o.
- R6: A grant while req_o is low is ignored: debt and bank_busy_o do not change. A grant while req_o is high lowers the debt by one.
- R7: An accepted grant holds the target banks busy (bank_busy_o bit n = bank n) for exactly ceil(RFC_PS / CLK_PS) cycles, 17 at defaults.
- R8: Each accepted per-bank grant advances req_bank_o by one, wrapping from 7 to 0.
- R9: Debt never exceeds 8. Further interval boundaries at 8 are dropped. urgent_o is high while debt equals 8.
- R10: An interval boundary and an accepted grant in the same cycle leave the debt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = all-bank refresh, 1 = per-bank refresh |
| rate_i | input | 2 | Rate code: 0 = 1x, 1 = 2x, 2 or 3 = 4x |
| gnt_i | input | 1 | Arbiter grant for the current request |
| req_o | output | 1 | Refresh request |
| req_all_o | output | 1 | The request targets all banks |
| req_bank_o | output | 3 | Target bank for a per-bank request |
| urgent_o | output | 1 | Debt is at its limit; serve refresh first |
| debt_o | output | 4 | Number of refreshes owed |
| bank_busy_o | output | 8 | Per-bank refresh-in-progress flags |

## Verification
The most delicate case is an interval boundary landing in the same cycle as an accepted grant, where the increment and the decrement must cancel. The bench provokes this by timing a grant from an observed debt increment: at the 4x per-bank interval of 15 cycles, it asserts the grant fourteen cycles after the increment becomes visible. It then judges that the debt on the port is unchanged one cycle later. The same overlap is examined at the saturation limit, where a boundary at full debt must be dropped while back-to-back grants walk the bank pointer.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

  typedef enum logic [1:0] {
    RATE_1X  = 2'd0,
    RATE_2X  = 2'd1,
    RATE_4X  = 2'd2,
    RATE_4XB = 2'd3
  } rate_e;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned rate_shift(input logic [1:0] r);
    case (rate_e'(r))
      RATE_1X: return 0;
      RATE_2X: return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/ref_ivl_timer.sv
module ref_ivl_timer
  import ref_sched_pkg::*;
#(
  parameter int unsigned CLK_PS  = 8000,
  parameter int unsigned REFI_PS = 3_900_000,
  parameter int unsigned NB      = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_i,
  input  logic [1:0] rate_i,
  output logic       tick_o,
  output logic       mode_q_o
);

  localparam int unsigned P_AB = ceil_div(REFI_PS, CLK_PS);
  localparam int unsigned P_PB = ceil_div(REFI_PS / NB, CLK_PS);
  localparam int unsigned CW   = $clog2(P_AB + 1);

  function automatic int unsigned period(input logic m, input logic [1:0] r);
    int unsigned base;
    int unsigned p;
    base = m ? P_PB : P_AB;
    p    = base >> rate_shift(r);
    return (p == 0) ? 1 : p;
  endfunction

  logic [CW-1:0] cnt_q;
  logic          mode_q;

  assign tick_o   = (cnt_q == '0);
  assign mode_q_o = mode_q;

  // settings are sampled only at the boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(P_AB - 1);
      mode_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q  <= CW'(period(mode_i, rate_i) - 1);
      mode_q <= mode_i;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
  parameter int unsigned MAX_DEBT = 8,
  localparam int unsigned DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [DW-1:0] debt_o,
  output logic          full_o
);

  logic [DW-1:0] debt_q, debt_d;

  assign full_o = (debt_q == DW'(MAX_DEBT));
  assign debt_o = debt_q;

  always_comb begin
    debt_d = debt_q;
    case ({inc_i, dec_i})
      2'b10:   if (!full_o) debt_d = debt_q + 1'b1;
      2'b01:   if (debt_q != '0) debt_d = debt_q - 1'b1;
      default: debt_d = debt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) debt_q <= '0;
    else         debt_q <= debt_d;
  end

endmodule

// File: rtl/ref_bank_busy.sv
module ref_bank_busy #(
  parameter int unsigned NB      = 8,
  parameter int unsigned RFC_CYC = 17,
  localparam int unsigned RW = $clog2(RFC_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] load_i,
  output logic [NB-1:0] busy_o
);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (load_i[b])      cnt_q <= RW'(RFC_CYC);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o[b] = (cnt_q != '0);
  end

endmodule

// File: rtl/ref_sched.sv
module ref_sched
  import ref_sched_pkg::*;
#(
  parameter int unsigned NB       = 8,
  parameter int unsigned CLK_PS   = 8000,
  parameter int unsigned REFI_PS  = 3_900_000,
  parameter int unsigned RFC_PS   = 130_000,
  parameter int unsigned MAX_DEBT = 8,
  localparam int unsigned BW      = $clog2(NB),
  localparam int unsigned DW      = $clog2(MAX_DEBT + 1),
  localparam int unsigned RFC_CYC = ceil_div(RFC_PS, CLK_PS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [1:0]    rate_i,
  input  logic          gnt_i,
  output logic          req_o,
  output logic          req_all_o,
  output logic [BW-1:0] req_bank_o,
  output logic          urgent_o,
  output logic [DW-1:0] debt_o,
  output logic [NB-1:0] bank_busy_o
);

  logic          tick;
  logic          mode_q;
  logic          acc;
  logic          tgt_idle;
  logic [BW-1:0] ptr_q;
  logic [NB-1:0] load;
  logic [NB-1:0] busy;
  logic [DW-1:0] debt;

  ref_ivl_timer #(
    .CLK_PS (CLK_PS),
    .REFI_PS(REFI_PS),
    .NB     (NB)
  ) u_ivl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .rate_i  (rate_i),
    .tick_o  (tick),
    .mode_q_o(mode_q)
  );

  ref_debt_ctr #(
    .MAX_DEBT(MAX_DEBT)
  ) u_debt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (tick),
    .dec_i (acc),
    .debt_o(debt),
    .full_o(urgent_o)
  );

  ref_bank_busy #(
    .NB     (NB),
    .RFC_CYC(RFC_CYC)
  ) u_busy (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .busy_o(busy)
  );

  assign tgt_idle = mode_q ? !busy[ptr_q] : (busy == '0);
  assign req_o    = (debt != '0) && tgt_idle;
  assign acc      = gnt_i && req_o;

  always_comb begin
    load = '0;
    if (acc) begin
      if (mode_q) load[ptr_q] = 1'b1;
      else        load = '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ptr_q <= '0;
    else if (acc && mode_q)  ptr_q <= (ptr_q == BW'(NB - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign req_all_o   = !mode_q;
  assign req_bank_o  = ptr_q;
  assign debt_o      = debt;
  assign bank_busy_o = busy;

endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
  parameter int unsigned NB       = 8,
  parameter int unsigned MAX_DEBT = 8,
  localparam int unsigned BW = $clog2(NB),
  localparam int unsigned DW = $clog2(MAX_DEBT + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          gnt_i,
  input logic          tick_i,
  input logic          req_o,
  input logic          req_all_o,
  input logic [BW-1:0] req_bank_o,
  input logic          urgent_o,
  input logic [DW-1:0] debt_o,
  input logic [NB-1:0] bank_busy_o
);

  a_r9_debt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debt_o <= DW'(MAX_DEBT));

  a_r9_urgent_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urgent_o && !(req_o && gnt_i)) |=> urgent_o);

  a_r5_all_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && req_all_o) |-> (bank_busy_o == '0));

  a_r6_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && gnt_i) |=> (debt_o >= $past(debt_o)));

  a_r6_accept_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i && !tick_i) |=> (debt_o == $past(debt_o) - 1'b1));

  a_r10_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i && tick_i) |=> $stable(debt_o));

  a_r7_all_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i && req_all_o) |=> (bank_busy_o == '1));

  a_r8_rr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i && !req_all_o) |=>
      (req_bank_o == (($past(req_bank_o) == BW'(NB - 1)) ? '0 : $past(req_bank_o) + 1'b1)));

endmodule

bind ref_sched ref_sched_chk #(
  .NB      (NB),
  .MAX_DEBT(MAX_DEBT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gnt_i      (gnt_i),
  .tick_i     (tick),
  .req_o      (req_o),
  .req_all_o  (req_all_o),
  .req_bank_o (req_bank_o),
  .urgent_o   (urgent_o),
  .debt_o     (debt_o),
  .bank_busy_o(bank_busy_o)
);

// File: tb/sim_ref_sched.sv
`timescale 1ns/1ps
module sim_ref_sched;

  localparam int CLK_PS  = 8000;
  localparam int EXP_AB  = (3900000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_PB  = (487500 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_RFC = (130000 + CLK_PS - 1) / CLK_PS;

  typedef struct packed {
    logic        m;
    logic [1:0]  r;
    logic [31:0] p;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b0, 2'd0, 32'(EXP_AB)},
    '{1'b0, 2'd1, 32'(EXP_AB / 2)},
    '{1'b0, 2'd2, 32'(EXP_AB / 4)},
    '{1'b0, 2'd3, 32'(EXP_AB / 4)},
    '{1'b1, 2'd0, 32'(EXP_PB)},
    '{1'b1, 2'd1, 32'(EXP_PB / 2)},
    '{1'b1, 2'd2, 32'(EXP_PB / 4)}
  };

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       mode_i;
  logic [1:0] rate_i;
  logic       gnt_i;
  logic       req_o, req_all_o, urgent_o;
  logic [2:0] req_bank_o;
  logic [3:0] debt_o;
  logic [7:0] bank_busy_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ref_sched #(.CLK_PS(CLK_PS)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .rate_i     (rate_i),
    .gnt_i      (gnt_i),
    .req_o      (req_o),
    .req_all_o  (req_all_o),
    .req_bank_o (req_bank_o),
    .urgent_o   (urgent_o),
    .debt_o     (debt_o),
    .bank_busy_o(bank_busy_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic measure(output int n);
    int  prev;
    bit  found;
    prev  = debt_o;
    n     = 0;
    found = 0;
    while (!found) begin
      @(negedge clk);
      n++;
      if (debt_o > prev) found = 1;
      else prev = debt_o;
    end
  endtask

  task automatic drain();
    while (debt_o != 0) begin
      gnt_i = req_o;
      @(negedge clk);
    end
    gnt_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int n, d, prev_p, prev_b, cnt, hi_req;
    rst_ni = 1'b0;
    gnt_i  = 1'b0;
    mode_i = 1'b0;
    rate_i = 2'd0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 req", req_o, 0);
    chk("R1 debt", debt_o, 0);
    chk("R1 busy", bank_busy_o, 0);
    chk("R1 urgent", urgent_o, 0);
    chk("R1 all-bank mode", req_all_o, 1);

    // R6 grant with no request is ignored
    gnt_i = 1'b1;
    @(negedge clk);
    gnt_i = 1'b0;
    chk("R6 idle grant debt", debt_o, 0);
    chk("R6 idle grant busy", bank_busy_o, 0);

    // vector table: interval before (R4) and after (R2/R3) each change
    prev_p = EXP_AB;
    for (int i = 0; i < 7; i++) begin
      drain();
      measure(n);
      mode_i = VEC[i].m;
      rate_i = VEC[i].r;
      measure(n);
      chk("R4 running interval kept", n, prev_p);
      measure(n);
      chk(VEC[i].m ? "R3 per-bank interval" : "R2 all-bank interval", n, int'(VEC[i].p));
      prev_p = int'(VEC[i].p);
    end

    // R9 saturation at per-bank 4x
    drain();
    while (debt_o != 8) @(negedge clk);
    chk("R9 urgent at limit", urgent_o, 1);
    repeat (40) @(negedge clk);
    chk("R9 debt saturated", debt_o, 8);
    chk("R9 urgent held", urgent_o, 1);

    // R8 round robin across a wrap
    prev_b = 0;
    cnt    = 0;
    while (cnt < 9) begin
      if (req_o) begin
        if (cnt > 0) chk("R8 bank order", req_bank_o, (prev_b + 1) % 8);
        prev_b = req_bank_o;
        cnt++;
        gnt_i = 1'b1;
      end else begin
        gnt_i = 1'b0;
      end
      @(negedge clk);
    end
    gnt_i = 1'b0;

    // R10 boundary and grant in one cycle
    drain();
    measure(n);
    measure(n);
    d = debt_o;
    repeat (14) @(negedge clk);
    chk("R10 request ready", req_o, 1);
    chk("R10 no early tick", debt_o, d);
    gnt_i = 1'b1;
    @(negedge clk);
    gnt_i = 1'b0;
    chk("R10 debt unchanged", debt_o, d);

    // R7/R5 all-bank busy window
    mode_i = 1'b0;
    rate_i = 2'd2;
    drain();
    measure(n);
    measure(n);
    while (debt_o < 2) @(negedge clk);
    chk("R5 all-bank request", req_o, 1);
    chk("R5 all-bank flag", req_all_o, 1);
    gnt_i = 1'b1;
    @(negedge clk);
    gnt_i = 1'b0;
    n      = 0;
    hi_req = 0;
    while (bank_busy_o == 8'hFF && n < 1000) begin
      if (req_o) hi_req++;
      n++;
      @(negedge clk);
    end
    chk("R7 busy cycles", n, EXP_RFC);
    chk("R5 held while busy", hi_req, 0);
    chk("R7 busy cleared", bank_busy_o, 0);
    chk("R5 request resumes", req_o, 1);

    summary();
  end

endmodule